// File: doc/BRIEF.md
# Programmable Divide PWM Generator

This block turns its clock into a pulse train whose period and high time are both whole multiples of the clock period. Three bytes set it up. The control byte holds a divide-by-two selector and a power-down flag. The period byte F sets the length of one output period. The high-time byte P sets how long the output stays high at the start of each period.

A host interface outside this block collects the bytes. It hands them over as one parallel load strobe, together with a code that says how many bytes the transfer held. A transfer can carry only the high time, the period and the high time, or all three bytes. An analog comparator outside the block reduces the threshold check to a logic fault flag.

The output stays low until the first full three-byte load. After that, a change to the period or the high time waits for the current period to finish. The fault flag pulls the output low in the same cycle and latches. The latch is released only by a later load that arrives while the flag is low. The power-down flag freezes the counters. Only a full load with that flag cleared brings the block back to active.

Top module: `pwm_divgen`

## Requirements
- R1: With CD = control bit 0, the output period is (F+1)·(CD+1) clock cycles.
- R2: The output is high for (P+1)·(CD+1) cycles at the start of each period and low for the rest. When P >= F, the output stays high for the whole period.
- R3: From reset, the output stays low until a full load (cfg_kind = 3). Loads with cfg_kind = 1 or 2 before that do not start the output.
- R4: A full load that leaves the block active starts a new period at once. The output is high in the cycle after the load strobe.
- R5: cfg_kind = 1 writes only the high time. cfg_kind = 2 writes the period and the high time. While running, these values take effect only when the current period ends, and the current period keeps its old timing.
- R6: While fault is high, the output is low in that same cycle, and the block enters a latched fault state.
- R7: The fault latch holds the output low until a load of any kind (cfg_kind != 0) arrives while fault is low. That load restarts the period, with the output high in the next cycle. A load that arrives in the same cycle as a fault does not clear the fault.
- R8: A full load with control bit 2 set enters power-down at once. The output goes low and counting stops. Partial loads do not wake the block. A full load with bit 2 clear restarts it.
- R9: Control bits 7 to 3 and bit 1 have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the output is derived from it |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | One-cycle strobe marking the end of a host transfer |
| cfg_kind | input | 2 | Bytes in the transfer: 1 high time, 2 period and high time, 3 all |
| cfg_ctrl | input | 8 | Control byte: bit 0 divide-by-two, bit 2 power-down |
| cfg_period | input | 8 | Period byte F |
| cfg_high | input | 8 | High-time byte P |
| fault | input | 1 | Threshold fault flag, active high |
| pwm_out | output | 1 | Modulated output |

## Verification
Two events can fall in the same cycle: a host load and a rising fault. The bench drives both in the same cycle at the start of a running period. It then checks that the output stays low and that the block stays latched, so the fault takes priority over the load. After that, a separate load made with fault low must release the block, and the output must be high one cycle later. The bench also collides a deferred load with the start of a period, and checks that the old timing finishes before the new timing begins.

// File: rtl/pwm_divgen_pkg.sv
package pwm_divgen_pkg;

    localparam int CTRL_W  = 8;
    localparam int CD_BIT  = 0;
    localparam int PD_BIT  = 2;
    localparam int KIND_W  = 2;

    typedef enum logic [KIND_W-1:0] {
        LD_NONE   = 2'd0,
        LD_HIGH   = 2'd1,
        LD_PER_HI = 2'd2,
        LD_ALL    = 2'd3
    } load_kind_e;

    typedef enum logic [1:0] {
        ST_UNCONF = 2'd0,
        ST_RUN    = 2'd1,
        ST_FAULT  = 2'd2,
        ST_PDOWN  = 2'd3
    } pwm_state_e;

endpackage

// File: rtl/pwm_cfg_shadow.sv
module pwm_cfg_shadow
    import pwm_divgen_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_i,
    input  logic [KIND_W-1:0]    kind_i,
    input  logic [CTRL_W-1:0]    ctrl_i,
    input  logic [DW-1:0]        period_i,
    input  logic [DW-1:0]        high_i,
    output logic                 full_o,
    output logic                 any_o,
    output logic                 nxt_cd_o,
    output logic                 nxt_pd_o,
    output logic [DW-1:0]        nxt_period_o,
    output logic [DW-1:0]        nxt_high_o
);

    logic          sh_cd_q, sh_pd_q;
    logic [DW-1:0] sh_period_q, sh_high_q;
    load_kind_e    kind;
    logic          unused_ctrl_bits;

    assign kind             = load_kind_e'(kind_i);
    assign unused_ctrl_bits = ^{ctrl_i[CTRL_W-1:PD_BIT+1], ctrl_i[1]};
    assign full_o           = load_i && (kind == LD_ALL);
    assign any_o            = load_i && (kind != LD_NONE);

    // Values visible to the counter: a load in this cycle is seen at once.
    always_comb begin
        nxt_cd_o     = sh_cd_q;
        nxt_pd_o     = sh_pd_q;
        nxt_period_o = sh_period_q;
        nxt_high_o   = sh_high_q;
        if (load_i) begin
            unique case (kind)
                LD_HIGH: begin
                    nxt_high_o = high_i;
                end
                LD_PER_HI: begin
                    nxt_period_o = period_i;
                    nxt_high_o   = high_i;
                end
                LD_ALL: begin
                    nxt_cd_o     = ctrl_i[CD_BIT];
                    nxt_pd_o     = ctrl_i[PD_BIT];
                    nxt_period_o = period_i;
                    nxt_high_o   = high_i;
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_cd_q     <= 1'b0;
            sh_pd_q     <= 1'b0;
            sh_period_q <= '0;
            sh_high_q   <= '0;
        end else begin
            sh_cd_q     <= nxt_cd_o;
            sh_pd_q     <= nxt_pd_o;
            sh_period_q <= nxt_period_o;
            sh_high_q   <= nxt_high_o;
        end
    end

endmodule

// File: rtl/pwm_period_ctr.sv
module pwm_period_ctr #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart_i,
    input  logic          run_i,
    input  logic          nxt_cd_i,
    input  logic [DW-1:0] nxt_period_i,
    input  logic [DW-1:0] nxt_high_i,
    output logic          boundary_o,
    output logic          high_phase_o,
    output logic [DW-1:0] cnt_o,
    output logic [DW-1:0] act_period_o,
    output logic [DW-1:0] act_high_o
);

    logic          act_cd_q;
    logic          phase_q;
    logic          tick;
    logic [DW-1:0] cnt_q, act_period_q, act_high_q;

    // Divide-by-two: advance only on every second cycle.
    assign tick         = !act_cd_q || phase_q;
    assign boundary_o   = run_i && tick && (cnt_q == act_period_q);
    assign high_phase_o = (cnt_q <= act_high_q);
    assign cnt_o        = cnt_q;
    assign act_period_o = act_period_q;
    assign act_high_o   = act_high_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q        <= '0;
            phase_q      <= 1'b0;
            act_cd_q     <= 1'b0;
            act_period_q <= '0;
            act_high_q   <= '0;
        end else if (restart_i || boundary_o) begin
            cnt_q        <= '0;
            phase_q      <= 1'b0;
            act_cd_q     <= nxt_cd_i;
            act_period_q <= nxt_period_i;
            act_high_q   <= nxt_high_i;
        end else if (run_i) begin
            phase_q <= !phase_q;
            if (tick) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/pwm_divgen.sv
module pwm_divgen
    import pwm_divgen_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic [KIND_W-1:0] cfg_kind,
    input  logic [CTRL_W-1:0] cfg_ctrl,
    input  logic [DW-1:0]     cfg_period,
    input  logic [DW-1:0]     cfg_high,
    input  logic              fault,
    output logic              pwm_out
);

    pwm_state_e    state_q, state_d;
    logic          restart;
    logic          full_load, any_load;
    logic          nxt_cd, nxt_pd;
    logic [DW-1:0] nxt_period, nxt_high;
    logic          boundary, high_phase;
    logic [DW-1:0] cnt, act_period, act_high;

    pwm_cfg_shadow #(.DW(DW)) u_shadow (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (cfg_load),
        .kind_i       (cfg_kind),
        .ctrl_i       (cfg_ctrl),
        .period_i     (cfg_period),
        .high_i       (cfg_high),
        .full_o       (full_load),
        .any_o        (any_load),
        .nxt_cd_o     (nxt_cd),
        .nxt_pd_o     (nxt_pd),
        .nxt_period_o (nxt_period),
        .nxt_high_o   (nxt_high)
    );

    pwm_period_ctr #(.DW(DW)) u_ctr (
        .clk          (clk),
        .rst_n        (rst_n),
        .restart_i    (restart),
        .run_i        (state_q == ST_RUN),
        .nxt_cd_i     (nxt_cd),
        .nxt_period_i (nxt_period),
        .nxt_high_i   (nxt_high),
        .boundary_o   (boundary),
        .high_phase_o (high_phase),
        .cnt_o        (cnt),
        .act_period_o (act_period),
        .act_high_o   (act_high)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_UNCONF;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and restart request
    always_comb begin
        state_d = state_q;
        restart = 1'b0;
        unique case (state_q)
            ST_UNCONF: begin
                if (full_load) begin
                    if (nxt_pd) begin
                        state_d = ST_PDOWN;
                    end else if (fault) begin
                        state_d = ST_FAULT;
                    end else begin
                        state_d = ST_RUN;
                        restart = 1'b1;
                    end
                end
            end
            ST_RUN: begin
                if (fault) begin
                    state_d = ST_FAULT;
                end else if (full_load && nxt_pd) begin
                    state_d = ST_PDOWN;
                end
            end
            ST_FAULT: begin
                if (!fault && any_load) begin
                    if (full_load && nxt_pd) begin
                        state_d = ST_PDOWN;
                    end else begin
                        state_d = ST_RUN;
                        restart = 1'b1;
                    end
                end
            end
            ST_PDOWN: begin
                if (full_load && !nxt_pd) begin
                    if (fault) begin
                        state_d = ST_FAULT;
                    end else begin
                        state_d = ST_RUN;
                        restart = 1'b1;
                    end
                end
            end
            default: begin
                state_d = ST_UNCONF;
            end
        endcase
    end

    // Output: fault overrides within the same cycle
    always_comb begin
        pwm_out = (state_q == ST_RUN) && high_phase && !fault;
    end

endmodule

// File: rtl/pwm_divgen_chk.sv
module pwm_divgen_chk
    import pwm_divgen_pkg::*;
#(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fault,
    input logic          pwm_out,
    input pwm_state_e    state_q,
    input logic          restart,
    input logic          boundary,
    input logic          full_load,
    input logic          any_load,
    input logic [DW-1:0] cnt,
    input logic [DW-1:0] act_period,
    input logic [DW-1:0] act_high
);

    AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= act_period); // R1

    AST_UNCONF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_UNCONF) |-> !pwm_out); // R3

    AST_RESTART_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (pwm_out || fault)); // R4

    AST_DEFERRED_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!boundary && !restart) |=> ($stable(act_period) && $stable(act_high))); // R5

    AST_FAULT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> !pwm_out); // R6

    AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_FAULT) && (fault || !any_load)) |=> (state_q == ST_FAULT)); // R7

    AST_PDOWN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_PDOWN) && !full_load) |=> ((state_q == ST_PDOWN) && !pwm_out)); // R8

endmodule

bind pwm_divgen pwm_divgen_chk #(.DW(DW)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fault      (fault),
    .pwm_out    (pwm_out),
    .state_q    (state_q),
    .restart    (restart),
    .boundary   (boundary),
    .full_load  (full_load),
    .any_load   (any_load),
    .cnt        (cnt),
    .act_period (act_period),
    .act_high   (act_high)
);

// File: tb/test_pwm_divgen.sv
`timescale 1ns/1ps
module test_pwm_divgen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_load = 1'b0;
    logic [1:0] cfg_kind = 2'd0;
    logic [7:0] cfg_ctrl = 8'd0;
    logic [7:0] cfg_period = 8'd0;
    logic [7:0] cfg_high = 8'd0;
    logic       fault = 1'b0;
    logic       pwm_out;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    pwm_divgen i_pwm_divgen (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_load   (cfg_load),
        .cfg_kind   (cfg_kind),
        .cfg_ctrl   (cfg_ctrl),
        .cfg_period (cfg_period),
        .cfg_high   (cfg_high),
        .fault      (fault),
        .pwm_out    (pwm_out)
    );

    function automatic int exp_high(int f, int p, int cd);
        return ((p >= f ? f : p) + 1) * (cd + 1);
    endfunction

    function automatic int exp_low(int f, int p, int cd);
        return (f + 1) * (cd + 1) - exp_high(f, p, cd);
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cfg_load = 1'b0;
        fault = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Drive at a negedge, sampled by one rising edge, return at next negedge.
    task automatic do_load(int kind, int ctrl, int per, int hi);
        cfg_load = 1'b1;
        cfg_kind = kind[1:0];
        cfg_ctrl = ctrl[7:0];
        cfg_period = per[7:0];
        cfg_high = hi[7:0];
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    // Starts at a negedge where a period has just begun (output high).
    task automatic run_lengths(output int hi, output int lo);
        hi = 0;
        lo = 0;
        while (pwm_out === 1'b1 && hi < 2000) begin
            hi++;
            @(negedge clk);
            cfg_load = 1'b0;
        end
        while (pwm_out === 1'b0 && lo < 2000) begin
            lo++;
            @(negedge clk);
        end
    endtask

    task automatic expect_low_for(int n, string req);
        int highs = 0;
        for (int i = 0; i < n; i++) begin
            if (pwm_out !== 1'b0) highs++;
            @(negedge clk);
        end
        check(highs == 0, req, highs, 0);
    endtask

    initial begin
        int hi, lo;
        process_start: begin end
        do_reset();
        check(pwm_out === 1'b0, "R3 reset", int'(pwm_out), 0);

        // R3: partial loads before configuration
        do_load(1, 0, 4, 1);
        do_load(2, 0, 4, 1);
        expect_low_for(10, "R3 partial before full");

        // R4 / R1 / R2 directed 4/1/0
        do_load(3, 8'h00, 4, 1);
        check(pwm_out === 1'b1, "R4 high after load", int'(pwm_out), 1);
        run_lengths(hi, lo);
        check(hi == 2, "R2 high 4/1", hi, 2);
        check(lo == 3, "R1 low 4/1", lo, 3);

        // R5: kind 1 at a period start, old timing first
        cfg_load = 1'b1; cfg_kind = 2'd1; cfg_high = 8'd0;
        run_lengths(hi, lo);
        check(hi == 2 && lo == 3, "R5 current period kept", hi * 100 + lo, 203);
        run_lengths(hi, lo);
        check(hi == 1 && lo == 4, "R5 new high applied", hi * 100 + lo, 104);

        // R5: kind 2 writes period and high
        cfg_load = 1'b1; cfg_kind = 2'd2; cfg_period = 8'd6; cfg_high = 8'd3;
        run_lengths(hi, lo);
        check(hi == 1 && lo == 4, "R5 kind2 deferred", hi * 100 + lo, 104);
        run_lengths(hi, lo);
        check(hi == 4 && lo == 3, "R5 kind2 applied", hi * 100 + lo, 403);

        // R6: fault drops the output in the same cycle
        @(negedge clk);
        fault = 1'b1;
        #1;
        check(pwm_out === 1'b0, "R6 immediate low", int'(pwm_out), 0);
        @(negedge clk);
        expect_low_for(3, "R6 held low");
        do_load(1, 0, 0, 2);
        fault = 1'b0;
        expect_low_for(4, "R7 load during fault no release");
        do_load(1, 0, 0, 2);
        check(pwm_out === 1'b1, "R7 release restarts", int'(pwm_out), 1);
        run_lengths(hi, lo);
        check(hi == 3 && lo == 4, "R7 timing after release", hi * 100 + lo, 304);

        // R7: fault and load in the same cycle, fault wins
        fault = 1'b1;
        do_load(1, 0, 0, 1);
        fault = 1'b0;
        expect_low_for(4, "R7 collision fault wins");
        do_load(1, 0, 0, 1);
        check(pwm_out === 1'b1, "R7 release after collision", int'(pwm_out), 1);

        // R8: power-down
        do_load(3, 8'h04, 5, 2);
        check(pwm_out === 1'b0, "R8 enter power-down", int'(pwm_out), 0);
        expect_low_for(8, "R8 stays down");
        do_load(1, 0, 0, 3);
        do_load(2, 0, 5, 3);
        expect_low_for(8, "R8 partial no wake");

        // R9: ignored control bits, bit2 clear wakes
        do_load(3, 8'hFA, 3, 1);
        check(pwm_out === 1'b1, "R8 wake on full load", int'(pwm_out), 1);
        run_lengths(hi, lo);
        check(hi == 2 && lo == 2, "R9 ignored bits", hi * 100 + lo, 202);

        // R2: high time not below period keeps output high
        do_reset();
        do_load(3, 8'h00, 3, 7);
        begin
            int lows = 0;
            for (int i = 0; i < 12; i++) begin
                if (pwm_out !== 1'b1) lows++;
                @(negedge clk);
            end
            check(lows == 0, "R2 full high when P>=F", lows, 0);
        end

        // R1 / R2 / R9 random
        void'($urandom(32'h5eed_1234));
        for (int it = 0; it < 12; it++) begin
            int f, p, cd, ctrl;
            f = 1 + int'($urandom % 30);
            p = int'($urandom % f);
            cd = int'($urandom % 2);
            ctrl = (int'($urandom % 32) << 3) | (int'($urandom % 2) << 1) | cd;
            do_reset();
            do_load(3, ctrl, f, p);
            run_lengths(hi, lo);
            check(hi == exp_high(f, p, cd), "R2 random high", hi, exp_high(f, p, cd));
            check(lo == exp_low(f, p, cd), "R1 random low", lo, exp_low(f, p, cd));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule